// File: doc/BRIEF.md
# Load Multiple Word Sequencer

This block performs a load-multiple-word operation for a 64-bit integer core. A start command gives a first target register index, a base register index with that register's value, and a signed 16-bit displacement. The sequencer then reads 32-bit words from consecutive word addresses. It writes each word, widened to 64 bits with zeros, into consecutive general registers, ending with register 31.

Memory reads use two valid/ready channels. The request channel carries an address. The response channel carries the word. Only one read is ever in flight. The sequencer holds a request until memory accepts it, and it raises response-ready only while it waits for that one word. Memory may therefore stall either channel for any number of cycles. The register-file write port is a plain one-cycle strobe with an index and 64-bit data. Plain busy and done pins report the progress of the operation.

Top module: `ldm_seq`

## Requirements
- R1: The first read address is the sign-extended 16-bit displacement added to the base value. When the base index is 0, the base is the constant 0 and the supplied base value is ignored.
- R2: Register writes cover every index from the start index up to 31, in increasing order, one write per word. This makes 32 minus the start index writes in total: one write for start index 31 and 32 writes for start index 0.
- R3: Each write carries the returned word in bits 31:0 and zeros in bits 63:32.
- R4: Each read address after the first is the previous read address plus 4.
- R5: At most one read is outstanding. After a request is accepted, no new request is raised until the response has been taken, and response-ready is high only while a response is awaited.
- R6: A request that is not accepted stays valid, and its address stays unchanged, until it is accepted.
- R7: The write strobe is high for exactly one cycle per loaded word.
- R8: Done is high for one cycle, in the cycle after the write to register 31. Busy is low in the cycle after done.
- R9: A start asserted while busy is high has no effect on the running operation. It does not change the writes, the addresses or the number of reads.
- R10: After reset, busy, done, the write strobe, request-valid and response-ready are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin an operation (sampled when not busy) |
| rt_idx_i | input | 5 | First target register index |
| ra_idx_i | input | 5 | Base register index (0 selects constant zero) |
| ra_val_i | input | 64 | Base register value |
| disp_i | input | 16 | Signed displacement |
| mem_req_valid_o | output | 1 | Read request valid |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_addr_o | output | 64 | Read byte address |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_ready_o | output | 1 | Sequencer accepts read data |
| mem_rsp_data_i | input | 32 | Read word |
| rf_we_o | output | 1 | Register write strobe |
| rf_idx_o | output | 5 | Register write index |
| rf_data_o | output | 64 | Register write data |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that memory raises response-valid only for a request it has already accepted, and that it returns exactly one word per accepted request. The response-ordering and single-outstanding checks rely on this. The bench memory keeps its own pending flag, which it sets on an observed request handshake and clears on the response handshake. It offers a response only while that flag is set, so the stimulus stays within this assumption. A shifting pattern drives the ready and valid stalls, and one run uses no stalls at all.

// File: rtl/ldm_pkg.sv
package ldm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_WRITE,
    ST_DONE
  } ldm_state_e;
endpackage

// File: rtl/ldm_addr.sv
module ldm_addr #(
  parameter int XLEN   = 64,
  parameter int DISP_W = 16,
  parameter int STEP   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              step_i,
  input  logic              base_zero_i,
  input  logic [XLEN-1:0]   base_i,
  input  logic [DISP_W-1:0] disp_i,
  output logic [XLEN-1:0]   addr_o
);
  localparam logic [XLEN-1:0] STEP_V = XLEN'(STEP);

  logic [XLEN-1:0] base_sel;
  logic [XLEN-1:0] disp_ext;

  assign base_sel = base_zero_i ? '0 : base_i;
  assign disp_ext = {{(XLEN-DISP_W){disp_i[DISP_W-1]}}, disp_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      addr_o <= '0;
    else if (load_i) addr_o <= base_sel + disp_ext;
    else if (step_i) addr_o <= addr_o + STEP_V;
  end
endmodule

// File: rtl/ldm_ctrl.sv
module ldm_ctrl
  import ldm_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [IDX_W-1:0] rt_i,
  input  logic             req_ready_i,
  input  logic             rsp_valid_i,
  output ldm_state_e       state_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             load_o,
  output logic             step_o,
  output logic             capture_o
);
  localparam logic [IDX_W-1:0] LAST = '1;

  ldm_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_REQ;
      ST_REQ:   if (req_ready_i) state_d = ST_WAIT;
      ST_WAIT:  if (rsp_valid_i) state_d = ST_WRITE;
      ST_WRITE: state_d = (idx_o == LAST) ? ST_DONE : ST_REQ;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  assign load_o    = (state_q == ST_IDLE) && start_i;
  assign capture_o = (state_q == ST_WAIT) && rsp_valid_i;
  assign step_o    = (state_q == ST_WRITE) && (idx_o != LAST);
  assign state_o   = state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_o   <= '0;
    end else begin
      state_q <= state_d;
      if (load_o)      idx_o <= rt_i;
      else if (step_o) idx_o <= idx_o + 1'b1;
    end
  end
endmodule

// File: rtl/ldm_seq.sv
module ldm_seq
  import ldm_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int WORD_W = 32,
  parameter int IDX_W  = 5,
  parameter int DISP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [IDX_W-1:0]  rt_idx_i,
  input  logic [IDX_W-1:0]  ra_idx_i,
  input  logic [XLEN-1:0]   ra_val_i,
  input  logic [DISP_W-1:0] disp_i,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic [XLEN-1:0]   mem_addr_o,
  input  logic              mem_rsp_valid_i,
  output logic              mem_rsp_ready_o,
  input  logic [WORD_W-1:0] mem_rsp_data_i,
  output logic              rf_we_o,
  output logic [IDX_W-1:0]  rf_idx_o,
  output logic [XLEN-1:0]   rf_data_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int STEP = WORD_W / 8;

  ldm_state_e        state;
  logic              load, step, capture;
  logic [WORD_W-1:0] word_q;

  ldm_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .rt_i        (rt_idx_i),
    .req_ready_i (mem_req_ready_i),
    .rsp_valid_i (mem_rsp_valid_i),
    .state_o     (state),
    .idx_o       (rf_idx_o),
    .load_o      (load),
    .step_o      (step),
    .capture_o   (capture)
  );

  ldm_addr #(.XLEN(XLEN), .DISP_W(DISP_W), .STEP(STEP)) u_addr (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (load),
    .step_i      (step),
    .base_zero_i (ra_idx_i == '0),
    .base_i      (ra_val_i),
    .disp_i      (disp_i),
    .addr_o      (mem_addr_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       word_q <= '0;
    else if (capture) word_q <= mem_rsp_data_i;
  end

  assign mem_req_valid_o = (state == ST_REQ);
  assign mem_rsp_ready_o = (state == ST_WAIT);
  assign rf_we_o         = (state == ST_WRITE);
  assign rf_data_o       = {{(XLEN-WORD_W){1'b0}}, word_q};
  assign busy_o          = (state != ST_IDLE);
  assign done_o          = (state == ST_DONE);
endmodule

// File: rtl/ldm_seq_chk.sv
module ldm_seq_chk #(
  parameter int XLEN   = 64,
  parameter int WORD_W = 32,
  parameter int IDX_W  = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mem_req_valid_o,
  input logic             mem_req_ready_i,
  input logic [XLEN-1:0]  mem_addr_o,
  input logic             mem_rsp_valid_i,
  input logic             mem_rsp_ready_o,
  input logic             rf_we_o,
  input logic [IDX_W-1:0] rf_idx_o,
  input logic             done_o
);
  localparam logic [IDX_W-1:0] LAST   = '1;
  localparam logic [XLEN-1:0]  STEP_V = XLEN'(WORD_W / 8);

  logic             outst, wr_seen, req_seen;
  logic [IDX_W-1:0] last_idx;
  logic [XLEN-1:0]  last_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outst <= 1'b0; wr_seen <= 1'b0; req_seen <= 1'b0;
      last_idx <= '0; last_addr <= '0;
    end else begin
      if (mem_req_valid_o && mem_req_ready_i) begin
        outst <= 1'b1; req_seen <= 1'b1; last_addr <= mem_addr_o;
      end else if (mem_rsp_valid_i && mem_rsp_ready_o) begin
        outst <= 1'b0;
      end
      if (rf_we_o) begin
        wr_seen <= 1'b1; last_idx <= rf_idx_o;
      end
      if (done_o) begin
        wr_seen <= 1'b0; req_seen <= 1'b0;
      end
    end
  end

  p_one_outstanding_r5: assert property (@(posedge clk) disable iff (!rst_n)
    outst |-> !mem_req_valid_o);

  p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_addr_o)));

  p_we_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we_o |=> !rf_we_o);

  p_idx_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we_o && wr_seen) |-> (rf_idx_o == IDX_W'(last_idx + 1'b1)));

  p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid_o && mem_req_ready_i && req_seen) |-> (mem_addr_o == last_addr + STEP_V));

  p_done_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($past(rf_we_o) && $past(rf_idx_o) == LAST));
endmodule

bind ldm_seq ldm_seq_chk #(.XLEN(XLEN), .WORD_W(WORD_W), .IDX_W(IDX_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .mem_req_valid_o (mem_req_valid_o),
  .mem_req_ready_i (mem_req_ready_i),
  .mem_addr_o      (mem_addr_o),
  .mem_rsp_valid_i (mem_rsp_valid_i),
  .mem_rsp_ready_o (mem_rsp_ready_o),
  .rf_we_o         (rf_we_o),
  .rf_idx_o        (rf_idx_o),
  .done_o          (done_o)
);

// File: tb/sim_ldm_seq.sv
module sim_ldm_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [4:0]  rt_idx_i = '0, ra_idx_i = '0;
  logic [63:0] ra_val_i = '0;
  logic [15:0] disp_i = '0;
  logic        mem_req_valid_o, mem_req_ready_i = 1'b0;
  logic [63:0] mem_addr_o;
  logic        mem_rsp_valid_i = 1'b0, mem_rsp_ready_o;
  logic [31:0] mem_rsp_data_i = '0;
  logic        rf_we_o;
  logic [4:0]  rf_idx_o;
  logic [63:0] rf_data_o;
  logic        busy_o, done_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  ldm_seq u0 (.*);

  int checks = 0, fails = 0;
  bit finished = 0;

  function automatic logic [31:0] mem_word(input logic [63:0] a);
    return (a[31:0] * 32'h9E37_79B1) ^ 32'hC3C3_0F0F;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // reference model: 0 idle, 1 request, 2 waiting, 3 writing, 4 done
  int          ph = 0;
  int          cnt = 0;
  logic [63:0] maddr = '0;
  bit          pending = 0;
  logic [63:0] paddr = '0;
  logic [15:0] lfsr = 16'hACE1;
  bit          nostall = 0;
  int          wr_cnt = 0;
  bit          got_first = 0;
  logic [63:0] first_addr = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      // per-cycle comparison against the model
      check(mem_req_valid_o == (ph == 1), "R5 req_valid", 64'(mem_req_valid_o), 64'(ph == 1));
      if (ph == 1) check(mem_addr_o == maddr, "R4/R6 addr", mem_addr_o, maddr);
      check(mem_rsp_ready_o == (ph == 2), "R5 rsp_ready", 64'(mem_rsp_ready_o), 64'(ph == 2));
      check(rf_we_o == (ph == 3), "R7 rf_we", 64'(rf_we_o), 64'(ph == 3));
      if (ph == 3) begin
        check(rf_idx_o == 5'(cnt), "R2 rf_idx", 64'(rf_idx_o), 64'(cnt));
        check(rf_data_o == {32'h0, mem_word(maddr)}, "R3 rf_data", rf_data_o, {32'h0, mem_word(maddr)});
      end
      check(busy_o == (ph != 0), "R9 busy", 64'(busy_o), 64'(ph != 0));
      check(done_o == (ph == 4), "R8 done", 64'(done_o), 64'(ph == 4));
      if (rf_we_o) wr_cnt++;
      if (mem_req_valid_o && !got_first) begin got_first = 1; first_addr = mem_addr_o; end
    end
    // memory responder
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_req_ready_i = nostall | lfsr[0] | lfsr[3];
    mem_rsp_valid_i = pending & (nostall | lfsr[5] | lfsr[7]);
    mem_rsp_data_i  = mem_word(paddr);
    if (mem_rsp_valid_i && mem_rsp_ready_o) pending = 0;
    if (mem_req_valid_o && mem_req_ready_i) begin pending = 1; paddr = mem_addr_o; end
    // model advance for the coming edge
    if (!rst_n) ph = 0;
    else begin
      case (ph)
        0: if (start_i) begin
             cnt = int'(rt_idx_i);
             maddr = ((ra_idx_i == 0) ? 64'h0 : ra_val_i) + {{48{disp_i[15]}}, disp_i};
             ph = 1; wr_cnt = 0; got_first = 0;
           end
        1: if (mem_req_ready_i) ph = 2;
        2: if (mem_rsp_valid_i) ph = 3;
        3: if (cnt == 31) ph = 4; else begin cnt++; maddr = maddr + 64'd4; ph = 1; end
        default: ph = 0;
      endcase
    end
  end

  task automatic wait_done();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (done_o) break;
    end
    @(negedge clk);
    check(!busy_o && !done_o, "R8 idle after done", {busy_o, done_o}, 64'h0);
  endtask

  task automatic run_op(input logic [4:0] rt, input logic [4:0] ra, input logic [63:0] rv,
                        input logic [15:0] d, input bit intrude);
    logic [63:0] exp_first;
    exp_first = ((ra == 0) ? 64'h0 : rv) + {{48{d[15]}}, d};
    @(posedge clk); #1;
    start_i = 1; rt_idx_i = rt; ra_idx_i = ra; ra_val_i = rv; disp_i = d;
    @(posedge clk); #1;
    start_i = 0; rt_idx_i = ~rt; ra_val_i = ~rv; disp_i = ~d;
    if (intrude) begin
      repeat (9) @(posedge clk);
      #1; start_i = 1; rt_idx_i = 5'd0; ra_idx_i = 5'd3; ra_val_i = 64'h5555_0000; disp_i = 16'h0100;
      @(posedge clk); #1; start_i = 0;
    end
    wait_done();
    check(got_first && first_addr == exp_first, "R1 first addr", first_addr, exp_first);
    check(wr_cnt == 32 - int'(rt), "R2 write count", 64'(wr_cnt), 64'(32 - int'(rt)));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy_o && !done_o && !rf_we_o && !mem_req_valid_o && !mem_rsp_ready_o, "R10 reset state",
          {busy_o, done_o, rf_we_o, mem_req_valid_o, mem_rsp_ready_o}, 64'h0);
    @(posedge clk); #1 rst_n = 1;
    // R1: base index 0 ignores the base value; single word from index 31
    run_op(5'd31, 5'd0, 64'hDEAD_BEEF_0000_1000, 16'h0040, 0);
    // R2/R4: full run from index 0, negative displacement
    run_op(5'd0, 5'd7, 64'h0000_0001_0000_2000, 16'hFFF0, 0);
    // no stalls
    nostall = 1;
    run_op(5'd28, 5'd5, 64'h0000_0000_8000_0000, 16'h7FFC, 0);
    nostall = 0;
    // R9: start while busy is ignored
    run_op(5'd20, 5'd9, 64'h0000_0000_0040_0000, 16'h0008, 1);
    run_op(5'd30, 5'd1, 64'hFFFF_FFFF_FFFF_FFF0, 16'h0010, 0);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule